// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block interprets the write cycles that a host issues to a NOR-style flash device. Each write carries an address and a data word. The low byte of the data is read as a command. The decoder follows one-cycle and two-cycle command sequences, and also a page-buffer sequence whose length the host sets with a count word. It keeps the read mode that the read path uses: array, identifier/OTP, query or status.

The decoder turns each accepted sequence into a single-cycle request to the back end. The request carries an operation code, an address and a data word. Before it sends an erase or program, it checks the target block against a per-block lock vector and a reset-protect level. A refused request sets a sticky lock-error bit. A malformed sequence sets a sticky sequence-error bit. A busy flag from the back end stops new commands from being taken, except suspend and read-status.

The block has parameters for address width, block count, page-buffer depth and data width. The cell array, program/erase timing and electrical behaviour are out of scope.

Top module: `fcmd_decoder`

## Requirements
- R1: The command byte is wr_data[7:0]. The upper byte has no effect in command cycles. Any address is accepted. Command FFh sets rd_mode to 0 (array). 90h sets 1 (identifier/OTP). 98h sets 2 (query). 70h sets 3 (status). The new mode is visible in the cycle after the write.
- R2: Command 50h clears both status error bits and leaves rd_mode unchanged.
- R3: 20h followed by D0h issues op_code 1 (erase), with op_addr equal to the confirm address.
- R4: 40h or 10h followed by a write issues op_code 2 (program), with that write's address and its full 16-bit data.
- R5: E8h, then a count write whose low byte is N-1, then N data writes, then D0h to an address in the same block. Each data write issues op_code 3 (buffer load) with its own address and data. The confirm issues op_code 4 (commit), with op_addr equal to the E8h address and op_data equal to N.
- R6: Any of the following sets sts_seq_err, puts rd_mode at status, returns to idle and issues no request: an undefined first byte; N-1 of DEPTH or more; a wrong confirm byte (including a surplus data write); a confirm to another block.
- R7: B0h while busy issues op_code 9 (suspend). B0h while idle has no effect. D0h as a lone command while not busy issues op_code 10 (resume).
- R8: B8h followed by a write issues op_code 8 (status-pin configuration), with op_data set to the low byte of that write.
- R9: 60h followed by 01h issues op_code 5 (set the lock bit of the addressed block). 60h followed by D0h issues op_code 6 (clear all lock bits). Any other second byte is a sequence error.
- R10: C0h followed by a write issues op_code 7 (OTP program) with that address and data. Block locks and the reset-protect level do not affect it.
- R11: An erase, program or commit is refused, with no request and sts_lock_err set, if its block's lock bit is 1 or rp_high is 0.
- R12: sts_seq_err and sts_lock_err stay set until a 50h command.
- R13: The first cycle of an erase, program, page, lock, OTP or configuration sequence sets rd_mode to status. It stays at status until a read-mode command arrives.
- R14: While busy is 1, a first-cycle write other than B0h or 70h is ignored: no request, no mode change, no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | AW | Write address; top BW bits select the block |
| wr_data | input | DW | Write data; low byte is the command |
| blk_locked | input | NBLK | Lock bit per block |
| rp_high | input | 1 | Reset-protect level; 1 permits modification |
| busy | input | 1 | Back end operation in progress |
| rd_mode | output | 2 | Read mode: 0 array, 1 ident, 2 query, 3 status |
| op_valid | output | 1 | One-cycle request strobe |
| op_code | output | 4 | Request code |
| op_addr | output | AW | Request address |
| op_data | output | DW | Request data |
| sts_seq_err | output | 1 | Sticky command-sequence error |
| sts_lock_err | output | 1 | Sticky lock/protect error |

## Verification
Suppose the sequencer is left in a wrong state, for example a stale page count or a skipped confirm stage. The ports show it on the very next write: a request appears where none should, a request is missing, or sts_seq_err rises one cycle after a write that should have been legal. A wrong lock decision shows as a request with a locked block's address, or as a missing sts_lock_err, in the cycle after the confirm. The bench sweeps every block, several page lengths up to the buffer depth, and every read-mode command with varied upper bytes. It checks each outcome at the first cycle it can appear.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_ERASE  = 4'd1,
    OP_PROG   = 4'd2,
    OP_BUFLD  = 4'd3,
    OP_COMMIT = 4'd4,
    OP_LKSET  = 4'd5,
    OP_LKCLR  = 4'd6,
    OP_OTP    = 4'd7,
    OP_CFG    = 4'd8,
    OP_SUSP   = 4'd9,
    OP_RESUME = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'd0,
    MD_IDENT = 2'd1,
    MD_QUERY = 2'd2,
    MD_STAT  = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ERASE_CF, ST_PROG_DATA, ST_PAGE_CNT, ST_PAGE_DATA,
    ST_PAGE_CF, ST_CFG_CODE, ST_LOCK_CF, ST_OTP_DATA
  } st_e;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_IDENT = 8'h90;
  localparam logic [7:0] C_RD_QUERY = 8'h98;
  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_PROG_A   = 8'h40;
  localparam logic [7:0] C_PROG_B   = 8'h10;
  localparam logic [7:0] C_PAGE     = 8'hE8;
  localparam logic [7:0] C_SUSP     = 8'hB0;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_CFG      = 8'hB8;
  localparam logic [7:0] C_LOCK     = 8'h60;
  localparam logic [7:0] C_LOCK_SET = 8'h01;
  localparam logic [7:0] C_OTP      = 8'hC0;

  // page-buffer count word: low byte holds N-1
  function automatic bit page_len_ok(logic [7:0] n_minus1, int depth);
    return int'(n_minus1) < depth;
  endfunction

  function automatic int page_len(logic [7:0] n_minus1);
    return int'(n_minus1) + 1;
  endfunction

endpackage

// File: rtl/fcmd_guard.sv
module fcmd_guard #(
  parameter int NBLK = 8,
  localparam int BW = $clog2(NBLK)
) (
  input  logic [BW-1:0]   chk_blk,
  input  logic [NBLK-1:0] blk_locked,
  input  logic            rp_high,
  output logic            mod_ok
);
  assign mod_ok = rp_high && !blk_locked[chk_blk];
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_seq_err,
  input  logic ev_lock_err,
  input  logic ev_clear,
  output logic sts_seq_err,
  output logic sts_lock_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_seq_err  <= 1'b0;
      sts_lock_err <= 1'b0;
    end else if (ev_clear) begin
      sts_seq_err  <= 1'b0;
      sts_lock_err <= 1'b0;
    end else begin
      if (ev_seq_err)  sts_seq_err  <= 1'b1;
      if (ev_lock_err) sts_lock_err <= 1'b1;
    end
  end

  p_sticky_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sts_lock_err && !ev_clear |=> sts_lock_err);
  p_sticky_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sts_seq_err && !ev_clear |=> sts_seq_err);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> !sts_seq_err && !sts_lock_err);
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int NBLK  = 8,
  parameter int DEPTH = 32,
  localparam int BW   = $clog2(NBLK),
  localparam int SH   = AW - BW,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  input  logic          mod_ok,
  output logic [BW-1:0] chk_blk,
  output logic [1:0]    rd_mode,
  output logic          op_valid,
  output logic [3:0]    op_code,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          ev_seq_err,
  output logic          ev_lock_err,
  output logic          ev_clear
);
  st_e             state, nxt_state;
  mode_e           mode_q, nxt_mode;
  logic [CNTW-1:0] cnt, nxt_cnt, pg_n, nxt_pg_n;
  logic [AW-1:0]   pg_addr;
  logic [7:0]      cmd;
  logic [BW-1:0]   wr_blk, pg_blk;
  logic            idle_blocked, pg_start;
  logic            fire;
  op_e             fire_code;
  logic [AW-1:0]   fire_addr;
  logic [DW-1:0]   fire_data;

  assign cmd     = wr_data[7:0];
  assign wr_blk  = wr_addr[AW-1:SH];
  assign pg_blk  = pg_addr[AW-1:SH];
  assign chk_blk = (state == ST_PAGE_CF) ? pg_blk : wr_blk;
  assign idle_blocked = busy && (cmd != C_SUSP) && (cmd != C_RD_STAT);
  assign pg_start = wr_en && (state == ST_IDLE) && !idle_blocked && (cmd == C_PAGE);

  always_comb begin
    nxt_state   = state;
    nxt_mode    = mode_q;
    nxt_cnt     = cnt;
    nxt_pg_n    = pg_n;
    fire        = 1'b0;
    fire_code   = OP_NONE;
    fire_addr   = wr_addr;
    fire_data   = wr_data;
    ev_seq_err  = 1'b0;
    ev_lock_err = 1'b0;
    ev_clear    = 1'b0;
    if (wr_en) begin
      case (state)
        ST_IDLE: begin
          if (!idle_blocked) begin
            case (cmd)
              C_RD_ARRAY: nxt_mode = MD_ARRAY;
              C_RD_IDENT: nxt_mode = MD_IDENT;
              C_RD_QUERY: nxt_mode = MD_QUERY;
              C_RD_STAT:  nxt_mode = MD_STAT;
              C_CLR_STAT: ev_clear = 1'b1;
              C_ERASE:  begin nxt_state = ST_ERASE_CF;  nxt_mode = MD_STAT; end
              C_PROG_A,
              C_PROG_B: begin nxt_state = ST_PROG_DATA; nxt_mode = MD_STAT; end
              C_PAGE:   begin nxt_state = ST_PAGE_CNT;  nxt_mode = MD_STAT; end
              C_CFG:    begin nxt_state = ST_CFG_CODE;  nxt_mode = MD_STAT; end
              C_LOCK:   begin nxt_state = ST_LOCK_CF;   nxt_mode = MD_STAT; end
              C_OTP:    begin nxt_state = ST_OTP_DATA;  nxt_mode = MD_STAT; end
              C_SUSP: begin
                if (busy) begin
                  fire = 1'b1; fire_code = OP_SUSP; nxt_mode = MD_STAT;
                end
              end
              C_CONFIRM: begin fire = 1'b1; fire_code = OP_RESUME; end
              default: begin ev_seq_err = 1'b1; nxt_mode = MD_STAT; end
            endcase
          end
        end
        ST_ERASE_CF: begin
          nxt_state = ST_IDLE;
          if (cmd != C_CONFIRM)  ev_seq_err = 1'b1;
          else if (mod_ok) begin fire = 1'b1; fire_code = OP_ERASE; end
          else                   ev_lock_err = 1'b1;
        end
        ST_PROG_DATA: begin
          nxt_state = ST_IDLE;
          if (mod_ok) begin fire = 1'b1; fire_code = OP_PROG; end
          else        ev_lock_err = 1'b1;
        end
        ST_PAGE_CNT: begin
          if (page_len_ok(cmd, DEPTH)) begin
            nxt_cnt   = CNTW'(page_len(cmd));
            nxt_pg_n  = CNTW'(page_len(cmd));
            nxt_state = ST_PAGE_DATA;
          end else begin
            ev_seq_err = 1'b1;
            nxt_state  = ST_IDLE;
          end
        end
        ST_PAGE_DATA: begin
          fire      = 1'b1;
          fire_code = OP_BUFLD;
          nxt_cnt   = cnt - 1'b1;
          if (cnt == CNTW'(1)) nxt_state = ST_PAGE_CF;
        end
        ST_PAGE_CF: begin
          nxt_state = ST_IDLE;
          if (cmd != C_CONFIRM || wr_blk != pg_blk) ev_seq_err = 1'b1;
          else if (mod_ok) begin
            fire      = 1'b1;
            fire_code = OP_COMMIT;
            fire_addr = pg_addr;
            fire_data = DW'(pg_n);
          end else ev_lock_err = 1'b1;
        end
        ST_CFG_CODE: begin
          nxt_state = ST_IDLE;
          fire = 1'b1; fire_code = OP_CFG; fire_data = DW'(cmd);
        end
        ST_LOCK_CF: begin
          nxt_state = ST_IDLE;
          if (cmd == C_LOCK_SET)     begin fire = 1'b1; fire_code = OP_LKSET; end
          else if (cmd == C_CONFIRM) begin fire = 1'b1; fire_code = OP_LKCLR; end
          else                       ev_seq_err = 1'b1;
        end
        ST_OTP_DATA: begin
          nxt_state = ST_IDLE;
          fire = 1'b1; fire_code = OP_OTP;
        end
        default: nxt_state = ST_IDLE;
      endcase
      if (ev_seq_err) begin
        nxt_mode  = MD_STAT;
        nxt_state = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= MD_ARRAY;
      cnt      <= '0;
      pg_n     <= '0;
      pg_addr  <= '0;
      op_valid <= 1'b0;
      op_code  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      state    <= nxt_state;
      mode_q   <= nxt_mode;
      cnt      <= nxt_cnt;
      pg_n     <= nxt_pg_n;
      if (pg_start) pg_addr <= wr_addr;
      op_valid <= fire;
      op_code  <= fire_code;
      op_addr  <= fire_addr;
      op_data  <= fire_data;
    end
  end

  assign rd_mode = mode_q;

  p_busy_ignore_r14: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy && state == ST_IDLE && cmd != C_SUSP && cmd != C_RD_STAT
    |=> !op_valid && $stable(rd_mode));
  p_page_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PAGE_DATA |-> cnt != '0 && cnt <= CNTW'(DEPTH));
  p_seqerr_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_err |=> rd_mode == MD_STAT && !op_valid);
  p_commit_after_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_COMMIT |-> $past(state) == ST_PAGE_CF);
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int NBLK  = 8,
  parameter int DEPTH = 32,
  localparam int BW   = $clog2(NBLK),
  localparam int SH   = AW - BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NBLK-1:0] blk_locked,
  input  logic            rp_high,
  input  logic            busy,
  output logic [1:0]      rd_mode,
  output logic            op_valid,
  output logic [3:0]      op_code,
  output logic [AW-1:0]   op_addr,
  output logic [DW-1:0]   op_data,
  output logic            sts_seq_err,
  output logic            sts_lock_err
);
  logic [BW-1:0] chk_blk;
  logic          mod_ok, ev_seq_err, ev_lock_err, ev_clear;
  logic          lk_here;

  fcmd_seq #(.AW(AW), .DW(DW), .NBLK(NBLK), .DEPTH(DEPTH)) u_seq (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .busy, .mod_ok, .chk_blk,
    .rd_mode, .op_valid, .op_code, .op_addr, .op_data,
    .ev_seq_err, .ev_lock_err, .ev_clear
  );

  fcmd_guard #(.NBLK(NBLK)) u_guard (
    .chk_blk, .blk_locked, .rp_high, .mod_ok
  );

  fcmd_status u_status (
    .clk, .rst_n, .ev_seq_err, .ev_lock_err, .ev_clear, .sts_seq_err, .sts_lock_err
  );

  assign lk_here = blk_locked[wr_addr[AW-1:SH]];

  p_locked_no_modify_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_ERASE || op_code == OP_PROG)
    |-> $past(rp_high) && !$past(lk_here));
  p_op_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_en));
endmodule

// File: tb/fcmd_decoder_test.sv
`timescale 1ns/1ps
module fcmd_decoder_test;
  localparam int AW = 12, DW = 16, NBLK = 8, DEPTH = 32;
  localparam int BSZ = 1 << (AW - 3);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [NBLK-1:0] blk_locked = '0;
  logic            rp_high = 1'b1;
  logic            busy = 1'b0;
  logic [1:0]      rd_mode;
  logic            op_valid;
  logic [3:0]      op_code;
  logic [AW-1:0]   op_addr;
  logic [DW-1:0]   op_data;
  logic            sts_seq_err, sts_lock_err;

  int checks = 0, errors = 0;
  logic          g_v;
  logic [3:0]    g_c;
  logic [AW-1:0] g_a;
  logic [DW-1:0] g_d;

  always #2.5 clk = ~clk;

  fcmd_decoder #(.AW(AW), .DW(DW), .NBLK(NBLK), .DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    g_v = op_valid; g_c = op_code; g_a = op_addr; g_d = op_data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic exp_op(input string tag, input logic [3:0] c,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk({tag, " valid"}, 32'(g_v), 32'd1);
    chk({tag, " code"},  32'(g_c), 32'(c));
    chk({tag, " addr"},  32'(g_a), 32'(a));
    chk({tag, " data"},  32'(g_d), 32'(d));
  endtask

  task automatic no_op(input string tag);
    chk({tag, " no request"}, 32'(g_v), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("reset rd_mode", 32'(rd_mode), 0);
    chk("reset op_valid", 32'(op_valid), 0);
    chk("reset errors", {30'b0, sts_seq_err, sts_lock_err}, 0);

    // R1: read-mode sweep over addresses and upper bytes
    for (int i = 0; i < 16; i++) begin
      logic [7:0] up = 8'(i * 37 + 5);
      logic [AW-1:0] a = AW'(i * 251);
      logic [7:0] c;
      int m = i % 4;
      c = (m == 0) ? 8'hFF : (m == 1) ? 8'h90 : (m == 2) ? 8'h98 : 8'h70;
      wr(a, {up, c});
      chk("R1 mode", 32'(rd_mode), 32'(m));
      no_op("R1");
    end
    wr('0, 16'h00FF);

    // R3, R13: erase in every block
    for (int b = 0; b < NBLK; b++) begin
      logic [AW-1:0] a = AW'(b * BSZ + b + 3);
      wr(AW'(b * BSZ), 16'h0020);
      no_op("R3 setup");
      chk("R13 status after setup", 32'(rd_mode), 3);
      wr(a, 16'h77D0);
      exp_op("R3 erase", 4'd1, a, 16'h77D0);
      chk("R13 status held", 32'(rd_mode), 3);
    end
    wr('0, 16'h00FF);
    chk("R13 array after FF", 32'(rd_mode), 0);

    // R4: both program setups
    wr(12'h123, 16'h0040); wr(12'h456, 16'hBEEF);
    exp_op("R4 prog 40", 4'd2, 12'h456, 16'hBEEF);
    wr(12'h000, 16'h0010); wr(12'hFFF, 16'h1234);
    exp_op("R4 prog 10", 4'd2, 12'hFFF, 16'h1234);

    // R11, R12, R2: locked block and protect low
    blk_locked = 8'b0000_1000;
    wr(AW'(3 * BSZ), 16'h0020); wr(AW'(3 * BSZ + 9), 16'h00D0);
    no_op("R11 locked erase");
    chk("R11 lock_err", 32'(sts_lock_err), 1);
    wr('0, 16'h00FF);
    chk("R12 lock_err sticky", 32'(sts_lock_err), 1);
    chk("R2 mode before clear", 32'(rd_mode), 0);
    wr('0, 16'h0050);
    chk("R2 cleared", {30'b0, sts_seq_err, sts_lock_err}, 0);
    chk("R2 mode kept", 32'(rd_mode), 0);
    blk_locked = '0; rp_high = 1'b0;
    wr(12'h010, 16'h0040); wr(12'h010, 16'h5555);
    no_op("R11 rp low");
    chk("R11 rp low lock_err", 32'(sts_lock_err), 1);
    rp_high = 1'b1;
    wr('0, 16'h0050);

    // R5: page buffer of several lengths
    for (int t = 0; t < 3; t++) begin
      int n = (t == 0) ? 1 : (t == 1) ? 5 : DEPTH;
      logic [AW-1:0] base = AW'((t + 2) * BSZ);
      wr(base, 16'h00E8); no_op("R5 E8");
      wr(base, 16'(n - 1)); no_op("R5 count");
      for (int k = 0; k < n; k++) begin
        wr(base + AW'(k), 16'(k * 97 + 1));
        exp_op("R5 load", 4'd3, base + AW'(k), 16'(k * 97 + 1));
      end
      wr(base + AW'(40), 16'h00D0);
      exp_op("R5 commit", 4'd4, base, 16'(n));
      chk("R5 no error", 32'(sts_seq_err), 0);
    end

    // R6: count too large, surplus data, wrong block, unknown byte
    wr('0, 16'h00FF);
    wr(12'h200, 16'h00E8); wr(12'h200, 16'(DEPTH));
    no_op("R6 count");
    chk("R6 count seq_err", 32'(sts_seq_err), 1);
    chk("R6 status mode", 32'(rd_mode), 3);
    wr('0, 16'h0050);
    wr(12'h200, 16'h00E8); wr(12'h200, 16'h0001);
    wr(12'h200, 16'h1111); wr(12'h201, 16'h2222);
    wr(12'h202, 16'h3333);
    no_op("R6 surplus data");
    chk("R6 surplus seq_err", 32'(sts_seq_err), 1);
    wr('0, 16'h0050);
    wr(12'h200, 16'h00E8); wr(12'h200, 16'h0000);
    wr(12'h200, 16'h1111); wr(12'h400, 16'h00D0);
    no_op("R6 other block");
    chk("R6 block seq_err", 32'(sts_seq_err), 1);
    wr('0, 16'h0050);
    wr(12'h100, 16'h0020); wr(12'h100, 16'h00FF);
    no_op("R6 bad confirm");
    chk("R6 confirm seq_err", 32'(sts_seq_err), 1);
    wr('0, 16'h0050); wr('0, 16'h00FF);
    wr('0, 16'h0033);
    chk("R6 unknown seq_err", 32'(sts_seq_err), 1);
    chk("R6 unknown status", 32'(rd_mode), 3);
    wr('0, 16'h0050);

    // R7, R14: suspend / resume with busy
    wr('0, 16'h00FF);
    wr(12'h055, 16'h00B0);
    no_op("R7 suspend idle");
    chk("R7 idle suspend mode", 32'(rd_mode), 0);
    busy = 1'b1;
    wr(12'h055, 16'h0090);
    no_op("R14 busy ignore");
    chk("R14 mode kept", 32'(rd_mode), 0);
    wr(12'h055, 16'h0033);
    chk("R14 no error", 32'(sts_seq_err), 0);
    wr(12'h066, 16'h00B0);
    exp_op("R7 suspend", 4'd9, 12'h066, 16'h00B0);
    chk("R7 status mode", 32'(rd_mode), 3);
    wr(12'h066, 16'h00FF);
    chk("R14 FF ignored", 32'(rd_mode), 3);
    busy = 1'b0;
    wr(12'h077, 16'h00D0);
    exp_op("R7 resume", 4'd10, 12'h077, 16'h00D0);

    // R8: configuration
    wr('0, 16'h00B8); wr(12'h321, 16'h1203);
    exp_op("R8 cfg", 4'd8, 12'h321, 16'h0003);

    // R9: lock set, clear, bad byte
    wr('0, 16'h0060); wr(12'hA00, 16'h0001);
    exp_op("R9 set", 4'd5, 12'hA00, 16'h0001);
    wr('0, 16'h0060); wr(12'h001, 16'h00D0);
    exp_op("R9 clear", 4'd6, 12'h001, 16'h00D0);
    wr('0, 16'h0060); wr(12'h001, 16'h0002);
    no_op("R9 bad");
    chk("R9 seq_err", 32'(sts_seq_err), 1);
    wr('0, 16'h0050);

    // R10: OTP ignores locks and protect level
    blk_locked = '1; rp_high = 1'b0;
    wr('0, 16'h00C0); wr(12'h00F, 16'hCAFE);
    exp_op("R10 otp", 4'd7, 12'h00F, 16'hCAFE);
    chk("R10 no lock_err", 32'(sts_lock_err), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule